// File: doc/BRIEF.md
# Dual-Channel Prescaled PWM Generator

This block generates two independent pulse-width modulated outputs for a small microcontroller. It runs on the system oscillator clock. Each channel keeps a control register and a duty register and drives one output bit. Software loads both registers through a single-cycle write port, `wr_en` with a two-bit register address.

Each channel has a prescaler. It produces one count tick every `2 × divider` oscillator clocks, where the divider is 2, 4, 8 or 16, chosen by a two-bit code. A free-running period counter advances on each tick and wraps after 32 ticks (short mode) or after 256 ticks (long mode). The output is high while the counter is below the active duty value. A duty write goes into a shadow buffer. It reaches the comparator only when the counter wraps, so a period never changes its shape part way through.

Each channel runs a two-state machine:
- `ST_PRIME` is entered from reset and on every control write (transition *restart*). In this state the counters are held at zero, the shadow duty is copied to the active duty, and the output is low.
- On the next clock the machine moves unconditionally to `ST_RUN` (transition *launch*). In `ST_RUN` the prescaler and the counter run.
- A control write while in `ST_RUN` returns the machine to `ST_PRIME`.

Top module: `pwm_dual`

## Requirements
- R1: After reset both outputs are low. Every register is zero, which selects long mode, divider code 00 and duty 0.
- R2: Control bits [1:0] hold the divider code. Codes 00, 01, 10 and 11 give dividers 2, 4, 8 and 16. One counter tick lasts `2 × divider` clocks, so each duty step adds 4, 8, 16 or 32 clocks of high time.
- R3: Control bit 2 set selects short mode, with a period of 32 ticks. Bit 2 clear selects long mode, with a period of 256 ticks.
- R4: In short mode only duty bits [4:0] are compared. Duty bits [7:5] have no effect on the output.
- R5: In `ST_RUN` the output is high while the counter is below the active duty, so the high part comes first in each period. A duty of 0 keeps the output low for the whole period.
- R6: A duty write goes to a shadow buffer. The shadow value becomes active only at the next counter wrap, or on entry to `ST_PRIME`.
- R7: A write to the control register resets that channel's prescaler and counter. The output is low for exactly one clock (`ST_PRIME`). A fresh period then starts from count 0 with the shadow duty made active.
- R8: Address bit 1 selects the channel and address bit 0 selects the register (0 = control, 1 = duty). A write to one channel does not disturb the other channel's waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Bit 1 selects the channel, bit 0 selects control (0) or duty (1) |
| wr_data | input | 8 | Write data |
| pwm_out | output | 2 | PWM outputs, bit n belongs to channel n |

## Verification
A faulty prescaler, counter or active-duty register shows at the ports as a wrong number of high clocks, or a wrong high/low order, within the first full period after a restart. That period lasts at most 8192 clocks. A faulty `ST_PRIME` handling shows one clock after the control write: the output is not forced low, or the waveform starts shifted. The bench compares each output clock by clock against a model of a full period that it computes itself, so a wrong shadow load shows in the period that should still carry the old duty.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;
    // control field positions decoded by the channel
    localparam int CTL_SHORT_BIT = 2;

    typedef enum logic [0:0] {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } chan_state_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = (1 << SEL_W) + 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   span;
    logic [PRE_W-1:0] term;

    // span = 2 * divider = 4 << sel
    always_comb begin
        span = (PRE_W+1)'(1) << (32'(sel) + 32'd2);
        term = PRE_W'(span - (PRE_W+1)'(1));
        tick = run && (pre_q == term);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (clear || !run || tick)
            pre_q <= '0;
        else
            pre_q <= pre_q + PRE_W'(1);
    end

    // R2: the prescale count never passes its terminal value
    p_pre_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= term);
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_dual_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int SEL_W   = 2,
    parameter int SHORT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic              duty_we,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_o
);
    localparam int CTL_W = CTL_SHORT_BIT + 1;
    localparam logic [DATA_W-1:0] SHORT_LAST = DATA_W'((1 << SHORT_W) - 1);

    chan_state_e       state_q, state_d;
    logic [CTL_W-1:0]  ctrl_q;
    logic [DATA_W-1:0] dbuf_q, act_q, cnt_q;
    logic [DATA_W-1:0] last, eff;
    logic              short_mode, tick, wrap;

    assign short_mode = ctrl_q[CTL_SHORT_BIT];

    pwm_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (ctrl_we),
        .run   (state_q == ST_RUN),
        .sel   (ctrl_q[SEL_W-1:0]),
        .tick  (tick)
    );

    always_comb begin
        last = short_mode ? SHORT_LAST : '1;
        eff  = short_mode ? DATA_W'(act_q[SHORT_W-1:0]) : act_q;
        wrap = tick && (cnt_q == last);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: state_d = ST_RUN;     // launch
            ST_RUN:   state_d = ST_RUN;
        endcase
        if (ctrl_we)
            state_d = ST_PRIME;             // restart
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_PRIME;
        else
            state_q <= state_d;
    end

    // registers, counter and active duty
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            dbuf_q <= '0;
            act_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (ctrl_we)
                ctrl_q <= wr_data[CTL_W-1:0];
            if (duty_we)
                dbuf_q <= wr_data;
            if (state_q == ST_PRIME || wrap)
                act_q <= dbuf_q;
            if (ctrl_we || state_q == ST_PRIME || wrap)
                cnt_q <= '0;
            else if (tick)
                cnt_q <= cnt_q + DATA_W'(1);
        end
    end

    // output process
    always_comb begin
        pwm_o = (state_q == ST_RUN) && (cnt_q < eff);
    end

    // R7: a control write forces one low cycle
    p_prime_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> !pwm_o);
    // R3: in short mode the counter stays inside 32 ticks
    p_short_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        short_mode |-> (cnt_q < DATA_W'(1 << SHORT_W)));
    // R6: the active duty only moves at a wrap or in ST_PRIME
    p_act_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !wrap) |=> $stable(act_q));
    // R2: the counter only advances on a prescaler tick
    p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !tick && !ctrl_we) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_dual.sv
module pwm_dual #(
    parameter int DATA_W  = 8,
    parameter int SEL_W   = 2,
    parameter int SHORT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [1:0]        pwm_out
);
    localparam int N_CH = 2;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic sel_ch;
        assign sel_ch = wr_en && (wr_addr[1] == ch[0]);

        pwm_channel #(
            .DATA_W  (DATA_W),
            .SEL_W   (SEL_W),
            .SHORT_W (SHORT_W)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl_we (sel_ch && !wr_addr[0]),
            .duty_we (sel_ch && wr_addr[0]),
            .wr_data (wr_data),
            .pwm_o   (pwm_out[ch])
        );
    end

    // R8: address decode never strobes both channels at once
    p_one_channel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({g_ch[1].sel_ch, g_ch[0].sel_ch}));
endmodule

// File: tb/pwm_dual_bench.sv
module pwm_dual_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_dual u_pwm_dual (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] addr, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // control write, then the one-cycle low prime state is checked
    task automatic restart(input int ch, input logic [7:0] ctrl, input string req);
        write_reg({ch[0], 1'b0}, ctrl);
        check(pwm_out[ch] == 1'b0, req, pwm_out[ch], 0);
    endtask

    // compare one full period clock by clock, optional write at index mid_at
    task automatic profile(input int ch, input int eff, input int sel, input bit short_m,
                           input string req, input int mid_at,
                           input logic [1:0] mid_addr, input logic [7:0] mid_data);
        int p = 4 << sel;
        int n = short_m ? 32 : 256;
        int bad = 0;
        int highs = 0;
        for (int i = 0; i < n * p; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (pwm_out[ch]) highs++;
            if (pwm_out[ch] != (i < eff * p)) bad++;
            if (i == mid_at) begin
                wr_en = 1'b1; wr_addr = mid_addr; wr_data = mid_data;
            end
        end
        check(bad == 0, req, highs, eff * p);
    endtask

    task automatic t_reset();
        check(pwm_out == 2'b00, "R1 reset outputs", pwm_out, 0);
        repeat (3) @(negedge clk);
        check(pwm_out == 2'b00, "R1 idle after reset", pwm_out, 0);
        restart(0, 8'h00, "R7 prime");
        profile(0, 0, 0, 1'b0, "R1 R5 zero duty", -1, 2'b00, 8'h00);
    endtask

    task automatic t_long_mode();
        write_reg(2'b01, 8'd100);
        restart(0, 8'h00, "R7 prime");
        profile(0, 100, 0, 1'b0, "R2 R5 long duty 100", -1, 2'b00, 8'h00);
        write_reg(2'b01, 8'd255);
        restart(0, 8'h00, "R7 prime");
        profile(0, 255, 0, 1'b0, "R5 long duty 255", -1, 2'b00, 8'h00);
    endtask

    task automatic t_dividers();
        write_reg(2'b11, 8'd20);
        for (int s = 0; s < 4; s++) begin
            restart(1, 8'h04 | 8'(s), "R7 prime");
            profile(1, 20, s, 1'b1, "R2 R3 divider sweep", -1, 2'b00, 8'h00);
        end
    endtask

    task automatic t_short_mask();
        write_reg(2'b01, 8'hE5);
        restart(0, 8'h07, "R7 prime");
        profile(0, 5, 3, 1'b1, "R4 upper duty bits ignored", -1, 2'b00, 8'h00);
    endtask

    task automatic t_buffered();
        write_reg(2'b01, 8'd10);
        restart(0, 8'h04, "R7 prime");
        profile(0, 10, 0, 1'b1, "R6 old duty kept", 40, 2'b01, 8'd25);
        profile(0, 25, 0, 1'b1, "R6 new duty at wrap", -1, 2'b00, 8'h00);
    endtask

    task automatic t_restart();
        write_reg(2'b01, 8'd30);
        restart(0, 8'h04, "R7 prime");
        repeat (10) @(negedge clk);
        check(pwm_out[0] == 1'b1, "R5 high part first", pwm_out[0], 1);
        restart(0, 8'h05, "R7 mid-period restart low");
        profile(0, 30, 1, 1'b1, "R7 fresh period", -1, 2'b00, 8'h00);
    endtask

    task automatic t_independent();
        write_reg(2'b11, 8'd12);
        write_reg(2'b01, 8'd7);
        restart(0, 8'h04, "R7 prime");
        profile(0, 7, 0, 1'b1, "R8 ch0 unaffected by ch1 write", 50, 2'b10, 8'h06);
        restart(1, 8'h06, "R7 prime");
        profile(1, 12, 2, 1'b1, "R8 ch1 own duty", 60, 2'b01, 8'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_long_mode();
        t_dividers();
        t_short_mask();
        t_buffered();
        t_restart();
        t_independent();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule